// File: doc/BRIEF.md
# Training-Word Lane Deskew Controller

This block lines up a wide bundle of deserialized sensor lanes whose arrival times differ by nearly three bit periods. The per-lane fine delay covers well under that span. For every lane it first sweeps a fine sampling-delay tap across its whole usable range and watches whether the deserialized word holds steady at each tap. It then parks the tap in the middle of the longest steady stretch. After that it rotates the word boundary one bit at a time, using single-cycle slip requests to the deserializer, until the lane shows the expected training word exactly.

Fine delay only has to move the sampling point as far as the next clock edge. The coarse slips remove whatever whole-bit offset is left. Each lane runs its own controller, so wide bundles scale by a single count parameter. A registered summary flag reports that the whole bundle is aligned. The delay elements and deserializers sit outside the block: the block only drives their tap and slip controls and reads back their parallel words.

Top module: `lane_deskew_ctrl`

## Requirements
- R1: While reset is held and after release, every tap output is 0, and no slip, lock or error flag is set until a start request arrives.
- R2: After start, a lane steps its tap from 0 to TAPS-1. It waits SETTLE word clocks at each tap, then calls the tap stable when CHECK consecutive words are all identical. It then sets the tap to s+(n-1)/2, where s is the first tap and n the length of the longest stable run. When two runs are equally long, the lower one is used.
- R3: A lane that finds no stable tap during the sweep raises its error flag and issues no slip.
- R4: With the tap parked, a lane compares its word with the training word. On a mismatch it issues a one-cycle slip pulse and compares again SETTLE word clocks later. It raises its lock flag at the first exact match, so a lane whose word boundary is k bits off (one slip rotates the word by one bit) gets exactly k slips.
- R5: A lane that has not matched after WORD_W slips raises its error flag, having issued exactly WORD_W slip pulses.
- R6: A lane is never locked and in error at once. Its tap does not move while it stays locked.
- R7: The all-locked output is high one cycle after every lane is locked, and low whenever any lane is not locked.
- R8: A locked lane whose word differs from the training word while the training-active input is high drops its lock, which pulls all-locked low. The same mismatch has no effect while training-active is low.
- R9: A start request restarts every lane from any state on the next cycle: taps return to 0 and the lock and error flags clear. This also holds when a lock-losing mismatch arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to (re)align all lanes |
| train_on | input | 1 | High while the sensor is sending training words |
| train_word | input | WORD_W | Expected training word |
| lane_words | input | LANES*WORD_W | Deserialized word of each lane, lane 0 in the low bits |
| lane_taps | output | LANES*TAP_W | Fine delay tap per lane |
| lane_slip | output | LANES | One-cycle bit-slip request per lane |
| lane_locked | output | LANES | Lane aligned to the training word |
| lane_error | output | LANES | Lane failed to align |
| all_locked | output | 1 | Every lane locked |

## Verification
The two functions that can land in one cycle are the loss-of-lock check on a locked lane and a fresh start request. The bench provokes this by corrupting a locked lane's word with training-active high on the same clock edge at which start is pulsed. The correct outcome is that the restart wins: one cycle later all taps read 0 and no lane is locked, lost or in error. The bundle then realigns to the same taps and slip counts as before. A second overlap is all-locked being computed while one lane loses lock. It is judged by all-locked falling with that lane's flag while the other lanes stay locked with unchanged taps.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  typedef enum logic [2:0] {
    LS_IDLE,
    LS_SWEEP,
    LS_SLIP,
    LS_LOCK,
    LS_LOST,
    LS_ERR
  } lane_state_e;
endpackage

// File: rtl/dsk_run_tracker.sv
// Tracks the current run of stable taps and the longest run seen so far.
module dsk_run_tracker #(
  parameter int TAP_W = 4,
  localparam int LEN_W = TAP_W + 1
) (
  input  logic [TAP_W-1:0] tap,
  input  logic             good,
  input  logic [TAP_W-1:0] run_start,
  input  logic [LEN_W-1:0] run_len,
  input  logic [TAP_W-1:0] best_start,
  input  logic [LEN_W-1:0] best_len,
  output logic [TAP_W-1:0] run_start_n,
  output logic [LEN_W-1:0] run_len_n,
  output logic [TAP_W-1:0] best_start_n,
  output logic [LEN_W-1:0] best_len_n
);
  logic [LEN_W-1:0] len_inc;
  logic [TAP_W-1:0] st;

  always_comb begin
    len_inc      = run_len + LEN_W'(1);
    st           = (run_len == '0) ? tap : run_start;
    run_start_n  = run_start;
    run_len_n    = '0;
    best_start_n = best_start;
    best_len_n   = best_len;
    if (good) begin
      run_start_n = st;
      run_len_n   = len_inc;
      // strictly longer only: the lower of equal runs is kept
      if (len_inc > best_len) begin
        best_start_n = st;
        best_len_n   = len_inc;
      end
    end
  end
endmodule

// File: rtl/dsk_lane.sv
// Per-lane controller: tap sweep, centring, bit-slip search, lock watch.
module dsk_lane
  import dsk_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int TAPS   = 16,
  parameter int SETTLE = 4,
  parameter int CHECK  = 8,
  localparam int TAP_W = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              train_on,
  input  logic [WORD_W-1:0] train_word,
  input  logic [WORD_W-1:0] word,
  output logic [TAP_W-1:0]  tap_o,
  output logic              slip_o,
  output logic              locked_o,
  output logic              error_o
);
  localparam int LEN_W  = TAP_W + 1;
  localparam int CNT_W  = $clog2(SETTLE + CHECK + 1);
  localparam int SLIP_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0]  SETTLE_C = CNT_W'(SETTLE);
  localparam logic [CNT_W-1:0]  LAST_C   = CNT_W'(SETTLE + CHECK - 1);
  localparam logic [TAP_W-1:0]  TAP_LAST = TAP_W'(TAPS - 1);
  localparam logic [SLIP_W-1:0] SLIP_MAX = SLIP_W'(WORD_W);

  lane_state_e       state, state_n;
  logic [TAP_W-1:0]  tap, tap_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic              bad, bad_n;
  logic [WORD_W-1:0] prev, prev_n;
  logic [TAP_W-1:0]  run_start, run_start_n, best_start, best_start_n;
  logic [LEN_W-1:0]  run_len, run_len_n, best_len, best_len_n;
  logic [TAP_W-1:0]  t_run_start, t_best_start;
  logic [LEN_W-1:0]  t_run_len, t_best_len;
  logic [SLIP_W-1:0] slips, slips_n;
  logic              slip_q, slip_n;
  logic              good, en;

  assign good = !bad && (word == prev);

  dsk_run_tracker #(.TAP_W(TAP_W)) u_trk (
    .tap         (tap),
    .good        (good),
    .run_start   (run_start),
    .run_len     (run_len),
    .best_start  (best_start),
    .best_len    (best_len),
    .run_start_n (t_run_start),
    .run_len_n   (t_run_len),
    .best_start_n(t_best_start),
    .best_len_n  (t_best_len)
  );

  always_comb begin
    state_n      = state;
    tap_n        = tap;
    cnt_n        = cnt;
    bad_n        = bad;
    prev_n       = prev;
    run_start_n  = run_start;
    run_len_n    = run_len;
    best_start_n = best_start;
    best_len_n   = best_len;
    slips_n      = slips;
    slip_n       = 1'b0;
    if (start) begin
      state_n      = LS_SWEEP;
      tap_n        = '0;
      cnt_n        = '0;
      bad_n        = 1'b0;
      run_start_n  = '0;
      run_len_n    = '0;
      best_start_n = '0;
      best_len_n   = '0;
      slips_n      = '0;
    end else begin
      case (state)
        LS_SWEEP: begin
          prev_n = word;
          cnt_n  = cnt + CNT_W'(1);
          if (cnt >= SETTLE_C && word != prev) bad_n = 1'b1;
          if (cnt == LAST_C) begin
            run_start_n  = t_run_start;
            run_len_n    = t_run_len;
            best_start_n = t_best_start;
            best_len_n   = t_best_len;
            cnt_n        = '0;
            bad_n        = 1'b0;
            if (tap == TAP_LAST) begin
              if (t_best_len == '0) begin
                state_n = LS_ERR;
              end else begin
                state_n = LS_SLIP;
                tap_n   = t_best_start + TAP_W'((t_best_len - LEN_W'(1)) >> 1);
              end
            end else begin
              tap_n = tap + TAP_W'(1);
            end
          end
        end
        LS_SLIP: begin
          if (cnt != SETTLE_C) begin
            cnt_n = cnt + CNT_W'(1);
          end else if (word == train_word) begin
            state_n = LS_LOCK;
          end else if (slips == SLIP_MAX) begin
            state_n = LS_ERR;
          end else begin
            slip_n  = 1'b1;
            slips_n = slips + SLIP_W'(1);
            cnt_n   = '0;
          end
        end
        LS_LOCK: begin
          if (train_on && word != train_word) state_n = LS_LOST;
        end
        default: ;
      endcase
    end
  end

  assign en = start || state == LS_SWEEP || state == LS_SLIP || state == LS_LOCK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= LS_IDLE;
      tap        <= '0;
      cnt        <= '0;
      bad        <= 1'b0;
      prev       <= '0;
      run_start  <= '0;
      run_len    <= '0;
      best_start <= '0;
      best_len   <= '0;
      slips      <= '0;
      slip_q     <= 1'b0;
    end else begin
      slip_q <= slip_n;
      if (en) begin
        state      <= state_n;
        tap        <= tap_n;
        cnt        <= cnt_n;
        bad        <= bad_n;
        prev       <= prev_n;
        run_start  <= run_start_n;
        run_len    <= run_len_n;
        best_start <= best_start_n;
        best_len   <= best_len_n;
        slips      <= slips_n;
      end
    end
  end

  assign tap_o    = tap;
  assign slip_o   = slip_q;
  assign locked_o = (state == LS_LOCK);
  assign error_o  = (state == LS_ERR);
endmodule

// File: rtl/lane_deskew_ctrl.sv
module lane_deskew_ctrl #(
  parameter int LANES  = 8,
  parameter int WORD_W = 12,
  parameter int TAPS   = 16,
  parameter int SETTLE = 4,
  parameter int CHECK  = 8,
  localparam int TAP_W = $clog2(TAPS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    train_on,
  input  logic [WORD_W-1:0]       train_word,
  input  logic [LANES*WORD_W-1:0] lane_words,
  output logic [LANES*TAP_W-1:0]  lane_taps,
  output logic [LANES-1:0]        lane_slip,
  output logic [LANES-1:0]        lane_locked,
  output logic [LANES-1:0]        lane_error,
  output logic                    all_locked
);
  logic all_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dsk_lane #(
      .WORD_W(WORD_W),
      .TAPS  (TAPS),
      .SETTLE(SETTLE),
      .CHECK (CHECK)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .train_on  (train_on),
      .train_word(train_word),
      .word      (lane_words[g*WORD_W +: WORD_W]),
      .tap_o     (lane_taps[g*TAP_W +: TAP_W]),
      .slip_o    (lane_slip[g]),
      .locked_o  (lane_locked[g]),
      .error_o   (lane_error[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) all_q <= 1'b0;
    else        all_q <= &lane_locked;
  end

  assign all_locked = all_q && (&lane_locked);
endmodule

// File: rtl/lane_deskew_ctrl_chk.sv
module lane_deskew_ctrl_chk #(
  parameter int LANES = 8,
  parameter int TAP_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic [LANES*TAP_W-1:0] lane_taps,
  input logic [LANES-1:0]       lane_slip,
  input logic [LANES-1:0]       lane_locked,
  input logic [LANES-1:0]       lane_error,
  input logic                   all_locked
);
  // R4
  slip_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_slip & $past(lane_slip)) == '0);

  // R4
  no_slip_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_slip & lane_locked) == '0);

  // R6
  lock_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_locked & lane_error) == '0);

  // R7
  all_lock_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_locked |-> (lane_error == '0 && $past(lane_locked) == '1));

  // R9
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (lane_locked == '0 && lane_error == '0 && lane_taps == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_hold
    // R6
    tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_locked[g] && $past(lane_locked[g])) |-> $stable(lane_taps[g*TAP_W +: TAP_W]));
  end
endmodule

bind lane_deskew_ctrl lane_deskew_ctrl_chk #(.LANES(LANES), .TAP_W(TAP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .lane_taps  (lane_taps),
  .lane_slip  (lane_slip),
  .lane_locked(lane_locked),
  .lane_error (lane_error),
  .all_locked (all_locked)
);

// File: tb/lane_deskew_ctrl_test.sv
`timescale 1ns/1ps
module lane_deskew_ctrl_test;
  localparam int L  = 4;
  localparam int W  = 12;
  localparam int NT = 16;
  localparam int TW = 4;
  localparam logic [W-1:0] TRAIN = 12'h0F1;

  logic clk, rst_n, start, train_on;
  logic [L*W-1:0]  lane_words;
  logic [L*TW-1:0] lane_taps;
  logic [L-1:0]    lane_slip, lane_locked, lane_error;
  logic            all_locked;

  // behavioural delay/deserializer stub state
  logic [NT-1:0] mask [L];
  int            off  [L];
  logic          broken  [L];
  logic          corrupt [L];
  int            slips   [L];
  logic          clr, jit;

  int tests, fails;
  bit finished;

  lane_deskew_ctrl #(.LANES(L), .WORD_W(W), .TAPS(NT), .SETTLE(4), .CHECK(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .train_on(train_on),
    .train_word(TRAIN), .lane_words(lane_words), .lane_taps(lane_taps),
    .lane_slip(lane_slip), .lane_locked(lane_locked), .lane_error(lane_error),
    .all_locked(all_locked)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [W-1:0] rotl(input logic [W-1:0] v, input int n);
    logic [W-1:0] r = v;
    for (int i = 0; i < n; i++) r = {r[W-2:0], r[W-1]};
    return r;
  endfunction

  always @(posedge clk) begin
    jit <= ~jit;
    for (int l = 0; l < L; l++) begin
      if (clr) slips[l] <= 0;
      else if (lane_slip[l]) slips[l] <= slips[l] + 1;
    end
  end

  always_comb begin
    for (int l = 0; l < L; l++) begin
      logic [W-1:0] b;
      logic [TW-1:0] t;
      t = lane_taps[l*TW +: TW];
      b = broken[l] ? '0 : rotl(TRAIN, (off[l] + slips[l]) % W);
      if (!mask[l][t]) b = b ^ {W{jit}};
      if (corrupt[l]) b = b ^ {{(W-1){1'b0}}, 1'b1};
      lane_words[l*W +: W] = b;
    end
  end

  function automatic int exp_tap(input logic [NT-1:0] m);
    int bs = -1, bl = 0, rs = 0, rl = 0;
    for (int t = 0; t < NT; t++) begin
      if (m[t]) begin
        if (rl == 0) rs = t;
        rl++;
        if (rl > bl) begin bl = rl; bs = rs; end
      end else rl = 0;
    end
    return (bl == 0) ? -1 : bs + (bl - 1) / 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tap_of(input int l);
    return int'(lane_taps[l*TW +: TW]);
  endfunction

  task automatic set_lane(input int l, input logic [NT-1:0] m, input int o, input logic brk);
    mask[l] = m; off[l] = o; broken[l] = brk; corrupt[l] = 1'b0;
  endtask

  task automatic pulse_start(input int corrupt_lane);
    @(negedge clk);
    start = 1'b1; clr = 1'b1;
    if (corrupt_lane >= 0) corrupt[corrupt_lane] = 1'b1;
    @(negedge clk);
    start = 1'b0; clr = 1'b0;
    if (corrupt_lane >= 0) corrupt[corrupt_lane] = 1'b0;
  endtask

  task automatic wait_and_check(input string tag);
    int n = 0;
    while (((lane_locked | lane_error) != '1) && n < 3000) begin
      @(negedge clk); n++;
    end
    repeat (2) @(negedge clk);
    for (int l = 0; l < L; l++) begin
      int e = exp_tap(mask[l]);
      if (e < 0) begin
        // R3
        check(lane_error[l] && !lane_locked[l], "R3 error flag", lane_error[l], 1);
        check(slips[l] == 0, "R3 no slips", slips[l], 0);
      end else if (broken[l]) begin
        // R5
        check(lane_error[l] && !lane_locked[l], "R5 error flag", lane_error[l], 1);
        check(slips[l] == W, "R5 slip count", slips[l], W);
        check(tap_of(l) == e, "R2 centred tap", tap_of(l), e);
      end else begin
        // R2, R4
        check(lane_locked[l] && !lane_error[l], "R4 locked", lane_locked[l], 1);
        check(tap_of(l) == e, "R2 centred tap", tap_of(l), e);
        check(slips[l] == (W - off[l]) % W, "R4 slip count", slips[l], (W - off[l]) % W);
      end
    end
    // R7
    check(all_locked == (lane_locked == '1), {"R7 all_locked ", tag}, all_locked, lane_locked == '1);
  endtask

  task automatic t_reset;
    // R1
    check(lane_taps == '0, "R1 taps", int'(lane_taps), 0);
    check(lane_locked == '0 && lane_error == '0 && !all_locked, "R1 flags",
          int'({lane_locked, lane_error}), 0);
    repeat (20) @(negedge clk);
    check(slips[0] + slips[1] + slips[2] + slips[3] == 0, "R1 no slips",
          slips[0] + slips[1] + slips[2] + slips[3], 0);
    check(lane_locked == '0 && lane_error == '0, "R1 idle flags",
          int'({lane_locked, lane_error}), 0);
  endtask

  task automatic cfg_a;
    set_lane(0, 16'h00F0, 0, 1'b0);
    set_lane(1, 16'h0F00, 3, 1'b0);
    set_lane(2, 16'h001F, 7, 1'b0);
    set_lane(3, 16'hF000, 11, 1'b0);
  endtask

  task automatic t_basic;
    cfg_a();
    pulse_start(-1);
    wait_and_check("basic");
  endtask

  task automatic t_runs;
    set_lane(0, 16'h0E07, 1, 1'b0);
    set_lane(1, 16'h7C03, 6, 1'b0);
    set_lane(2, 16'hFFFF, 11, 1'b0);
    set_lane(3, 16'h8001, 0, 1'b0);
    pulse_start(-1);
    wait_and_check("runs");
  endtask

  task automatic t_failures;
    set_lane(0, 16'h03C0, 5, 1'b0);
    set_lane(1, 16'h0000, 0, 1'b0);
    set_lane(2, 16'h0F00, 0, 1'b1);
    set_lane(3, 16'h0030, 2, 1'b0);
    pulse_start(-1);
    wait_and_check("fail");
  endtask

  task automatic t_loss;
    int t1;
    cfg_a();
    pulse_start(-1);
    wait_and_check("relock");
    t1 = tap_of(1);
    @(negedge clk);
    train_on = 1'b0; corrupt[1] = 1'b1;
    repeat (6) @(negedge clk);
    // R8: ignored while training is off
    check(lane_locked == '1 && all_locked, "R8 ignored", int'(lane_locked), 15);
    // R6
    check(tap_of(1) == t1, "R6 tap held", tap_of(1), t1);
    train_on = 1'b1;
    repeat (3) @(negedge clk);
    check(lane_locked == 4'b1101 && lane_error == '0, "R8 lock lost",
          int'(lane_locked), 13);
    check(!all_locked, "R8 all_locked low", all_locked, 0);
    corrupt[1] = 1'b0;
  endtask

  task automatic t_collision;
    cfg_a();
    pulse_start(-1);
    wait_and_check("pre");
    // mismatch on locked lane 0 and start in the same cycle
    @(negedge clk);
    start = 1'b1; clr = 1'b1; corrupt[0] = 1'b1;
    @(negedge clk);
    start = 1'b0; clr = 1'b0; corrupt[0] = 1'b0;
    // R9
    check(lane_locked == '0 && lane_error == '0 && !all_locked, "R9 flags cleared",
          int'({lane_locked, lane_error}), 0);
    check(lane_taps == '0, "R9 taps zero", int'(lane_taps), 0);
    wait_and_check("R9 realign");
  endtask

  initial begin
    tests = 0; fails = 0; finished = 0;
    rst_n = 1'b0; start = 1'b0; train_on = 1'b1; clr = 1'b1; jit = 1'b0;
    for (int l = 0; l < L; l++) begin
      mask[l] = '1; off[l] = 0; broken[l] = 1'b0; corrupt[l] = 1'b0; slips[l] = 0;
    end
    repeat (3) @(negedge clk);
    check(lane_taps == '0 && lane_locked == '0 && lane_slip == '0, "R1 in reset",
          int'(lane_taps), 0);
    rst_n = 1'b1; clr = 1'b0;
    t_reset();
    t_basic();
    t_runs();
    t_failures();
    t_loss();
    t_collision();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule